// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with Receive Holding Buffer

This block is a byte-wide asynchronous serial port. Its transmit and receive directions have separate shift registers, so a word can go out while another comes in. Software drives it through three write-only registers, selected by a two-bit address. Address 0 loads the transmit word. Address 1 holds the control bits. Address 2 takes write-one commands. The receive word, the buffer-full state, the transmit-busy state and the sticky overrun flag are visible on output ports. Bit timing comes from an external enable tick that runs at sixteen times the bit rate.

When a received word finishes, it moves from the receive shift register into a one-word holding buffer. Software can read that buffer while the next frame is still being shifted in. Reading the buffer does not free it. Software frees it with an explicit write-one command. If another word completes before that command arrives, the overrun flag is set and the new word replaces the old one.

Top module: `sio_duplex`

## Requirements
- R1: After reset, txd is 1, tx_busy is 0, rx_full is 0, overrun is 0, and both interrupt outputs are 0. All control bits are 0.
- R2: A transmitted frame is made of a low start bit, then the 8 data bits least significant bit first, then a high stop bit. Each bit lasts 16 baud ticks. Whenever tx_busy is 0, txd is 1.
- R3: The control register is at address 1. Its bit 0 is the transmit enable. A write to address 2 with bit 0 set starts sending the word last written to address 0. It does this only if the transmit enable is 1 and no frame is in progress. Otherwise the command is ignored: tx_busy stays 0, or the frame already in progress continues unchanged.
- R4: tx_busy is 1 from the start of a frame until the end of its stop bit. If control bit 2 is set, tx_irq pulses high for one cycle after each frame completes.
- R5: Control bit 1 is the receive enable. With it set, a valid frame on rxd is stored in rx_data and sets rx_full. If control bit 3 is also set, rx_irq pulses for one cycle in the same cycle that rx_full is set.
- R6: A start edge on rxd is accepted only if the line is still low at the eighth tick after the edge. A shorter low pulse stores no word.
- R7: Writing address 2 with bit 1 set clears rx_full. Reading rx_data never clears it.
- R8: If a word completes while rx_full is 1, overrun is set and rx_data takes the new word. Overrun stays set until a write to address 2 with bit 2 set clears it. That clear does not change rx_full.
- R9: Transmit and receive can run at the same time without disturbing each other.
- R10: While the receive enable is 0, activity on rxd stores no word and leaves rx_full at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 command |
| wr_data | input | 8 | Register write data |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Transmission in progress |
| rx_data | output | 8 | Receive holding buffer |
| rx_full | output | 1 | Holding buffer holds an unreleased word |
| overrun | output | 1 | Sticky overrun flag |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Receive-complete pulse |

## Verification
The assertions assume three things about the inputs: baud_tick is a single-cycle pulse, command writes arrive on one clean cycle of wr_en, and rxd changes only at tick boundaries, long after the synchronizer has settled. The bench produces baud_tick from a divide-by-four counter. It changes wr_en, wr_addr, wr_data and rxd only on falling edges, and it holds each bit it drives on rxd for a full sixteen ticks. The glitch in the start-bit rejection test is the only exception to that rule.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;

  localparam int CTL_TXEN = 0;
  localparam int CTL_RXEN = 1;
  localparam int CTL_TXIE = 2;
  localparam int CTL_RXIE = 3;
  localparam int CTL_W    = 4;

  localparam int CMD_TRIG  = 0;
  localparam int CMD_RLS   = 1;
  localparam int CMD_OVCLR = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic [DATA_W:0]  sh_q;    // data bits plus stop bit; start bit driven at load
  logic [CNT_W-1:0] tcnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      tcnt_q <= '0;
      idx_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      txd    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && en) begin
          sh_q   <= {1'b1, data};
          tcnt_q <= '0;
          idx_q  <= '0;
          busy   <= 1'b1;
          txd    <= 1'b0;
        end
      end else if (en && tick) begin
        if (tcnt_q == CNT_W'(OSR - 1)) begin
          tcnt_q <= '0;
          if (idx_q == IDX_W'(FRAME_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            txd  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            txd   <= sh_q[0];
            sh_q  <= {1'b1, sh_q[DATA_W:1]};
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  output logic [DATA_W-1:0] word,
  output logic              done
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  rx_state_t              st_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BIT_W-1:0]       bit_q;

  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      word  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else if (tick) begin
        case (st_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!line) st_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == CNT_W'(OSR/2 - 1)) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_W'(OSR - 1)) begin
              cnt_q <= '0;
              word  <= {line, word[DATA_W-1:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == BIT_W'(DATA_W - 1)) st_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == CNT_W'(OSR - 1)) begin
              cnt_q <= '0;
              done  <= 1'b1;
              st_q  <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_rxbuf.sv
`timescale 1ns/1ps
module sio_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              release_buf,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (load) data <= word;
      if (load)             full <= 1'b1;
      else if (release_buf) full <= 1'b0;
      if (load && full) ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_duplex.sv
`timescale 1ns/1ps
module sio_duplex
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rxd,
  output logic              txd,
  output logic              tx_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [CTL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0] txw_q;
  logic              cmd_wr, cmd_trig, cmd_rls, cmd_ovclr;
  logic              tx_en, rx_en, tx_done, rx_done;
  logic [DATA_W-1:0] rx_word;

  assign cmd_wr    = wr_en && (wr_addr == REG_CMD);
  assign cmd_trig  = cmd_wr && wr_data[CMD_TRIG];
  assign cmd_rls   = cmd_wr && wr_data[CMD_RLS];
  assign cmd_ovclr = cmd_wr && wr_data[CMD_OVCLR];
  assign tx_en     = ctrl_q[CTL_TXEN];
  assign rx_en     = ctrl_q[CTL_RXEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      txw_q  <= '0;
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if (wr_en && wr_addr == REG_CTRL) ctrl_q <= wr_data[CTL_W-1:0];
      if (wr_en && wr_addr == REG_DATA) txw_q  <= wr_data;
      tx_irq <= tx_done && ctrl_q[CTL_TXIE];
      rx_irq <= rx_done && ctrl_q[CTL_RXIE];
    end
  end

  sio_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .en(tx_en), .start(cmd_trig),
    .data(txw_q), .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sio_rx #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .en(rx_en), .rxd(rxd),
    .word(rx_word), .done(rx_done)
  );

  sio_rxbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .load(rx_done), .word(rx_word),
    .release_buf(cmd_rls), .clr_ovr(cmd_ovclr),
    .data(rx_data), .full(rx_full), .ovr(overrun)
  );
endmodule

// File: rtl/sio_duplex_chk.sv
`timescale 1ns/1ps
module sio_duplex_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic tx_busy,
  input logic tx_irq,
  input logic rx_irq,
  input logic rx_full,
  input logic overrun,
  input logic tx_en,
  input logic trig
);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R3
  trig_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (trig && !tx_en && !tx_busy) |=> !tx_busy);

  // R4
  tx_irq_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (!tx_busy && $past(tx_busy, 2)));

  // R5
  rx_irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  // R8
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_full));
endmodule

bind sio_duplex sio_duplex_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .tx_busy(tx_busy), .tx_irq(tx_irq),
  .rx_irq(rx_irq), .rx_full(rx_full), .overrun(overrun),
  .tx_en(tx_en), .trig(cmd_trig)
);

// File: tb/sio_duplex_bench.sv
`timescale 1ns/1ps
module sio_duplex_bench;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rxd_drv = 1'b1, loop = 1'b0;
  logic       rxd;
  logic       txd, tx_busy, rx_full, overrun, tx_irq, rx_irq;
  logic [7:0] rx_data;
  int checks = 0, errors = 0, cyc = 0, tdiv = 0, txirq_n = 0, rxirq_n = 0;

  // upper byte: word to send, lower byte: word expected back
  localparam logic [15:0] VECS [0:5] = '{16'h0000, 16'hFFFF, 16'hA5A5,
                                         16'h5A5A, 16'h0101, 16'h8080};

  assign rxd = loop ? txd : rxd_drv;

  sio_duplex u_sio_duplex (
    .clk(clk), .rst(rst), .baud_tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rxd(rxd), .txd(txd), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin tdiv <= 0; tick <= 1'b0; end
    else begin tdiv <= (tdiv == 3) ? 0 : tdiv + 1; tick <= (tdiv == 3); end
  end

  always @(posedge clk) begin
    if (tx_irq) txirq_n++;
    if (rx_irq) rxirq_n++;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 4000 && tx_busy; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic tx_capture(output logic [9:0] bits);
    wait_ticks(8); @(negedge clk); bits[0] = txd;
    for (int j = 1; j < 10; j++) begin
      wait_ticks(16); @(negedge clk); bits[j] = txd;
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rxd_drv = 1'b0; wait_ticks(16);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); rxd_drv = b[j]; wait_ticks(16);
    end
    @(negedge clk); rxd_drv = 1'b1; wait_ticks(20);
    @(negedge clk);
  endtask

  initial begin
    logic [9:0] bits;
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_busy == 1'b0, "R1 tx_busy", tx_busy, 0);
    chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(!tx_irq && !rx_irq, "R1 irqs", {tx_irq, rx_irq}, 0);

    // R3: trigger while transmit disabled is ignored
    wr(2'd0, 8'h55); wr(2'd2, 8'h01); wait_ticks(20); @(negedge clk);
    chk(tx_busy == 1'b0 && txd == 1'b1, "R3 disabled trigger",
        {tx_busy, txd}, 2'b01);

    // R10: frame with receiver disabled is not stored
    send_rx(8'h3C);
    chk(rx_full == 1'b0, "R10 rx disabled", rx_full, 0);

    wr(2'd1, 8'h0F);
    loop = 1'b1;
    foreach (VECS[i]) begin
      n0 = txirq_n;
      wr(2'd0, VECS[i][15:8]);
      wr(2'd2, 8'h01);
      chk(tx_busy == 1'b1, "R4 busy during frame", tx_busy, 1);
      tx_capture(bits);
      chk(bits == {1'b1, VECS[i][7:0], 1'b0}, "R2 frame bits", bits,
          {1'b1, VECS[i][7:0], 1'b0});
      wait_idle();
      chk(txirq_n == n0 + 1, "R4 tx_irq count", txirq_n, n0 + 1);
      chk(rx_full == 1'b1 && rx_data == VECS[i][7:0], "R5 loopback word",
          {rx_full, rx_data}, {1'b1, VECS[i][7:0]});
      chk(overrun == 1'b0, "R8 no overrun", overrun, 0);
      wr(2'd2, 8'h02);
      chk(rx_full == 1'b0, "R7 release", rx_full, 0);
    end

    // R3: trigger during a frame is ignored
    n0 = txirq_n;
    wr(2'd0, 8'h0F); wr(2'd2, 8'h01); wait_ticks(40);
    wr(2'd0, 8'hF0); wr(2'd2, 8'h01);
    wait_idle();
    chk(tx_busy == 1'b0 && txirq_n == n0 + 1, "R3 busy trigger ignored",
        txirq_n - n0, 1);
    chk(rx_data == 8'h0F, "R3 original frame kept", rx_data, 8'h0F);
    chk(rx_full == 1'b1, "R7 read does not release", rx_full, 1);

    // R8: second word without release
    wr(2'd0, 8'hC6); wr(2'd2, 8'h01); wait_idle();
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    chk(rx_data == 8'hC6, "R8 buffer overwritten", rx_data, 8'hC6);
    wr(2'd2, 8'h04);
    chk(overrun == 1'b0 && rx_full == 1'b1, "R8 clear keeps full",
        {overrun, rx_full}, 2'b01);
    wr(2'd2, 8'h02);

    // R6: short low pulse rejected
    loop = 1'b0;
    n0 = rxirq_n;
    @(negedge clk); rxd_drv = 1'b0; wait_ticks(3);
    @(negedge clk); rxd_drv = 1'b1; wait_ticks(200); @(negedge clk);
    chk(rx_full == 1'b0 && rxirq_n == n0, "R6 glitch rejected", rx_full, 0);
    send_rx(8'hC3);
    chk(rx_full == 1'b1 && rx_data == 8'hC3, "R6 recovery word", rx_data, 8'hC3);
    chk(rxirq_n == n0 + 1, "R5 rx_irq count", rxirq_n, n0 + 1);
    wr(2'd2, 8'h02);

    // R9: simultaneous transmit and receive
    wr(2'd0, 8'h96); wr(2'd2, 8'h01);
    fork
      tx_capture(bits);
      send_rx(8'h69);
    join
    wait_idle();
    chk(bits == {1'b1, 8'h96, 1'b0}, "R9 tx frame in duplex", bits,
        {1'b1, 8'h96, 1'b0});
    chk(rx_full == 1'b1 && rx_data == 8'h69, "R9 rx word in duplex",
        rx_data, 8'h69);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule